// File: doc/BRIEF.md
# Radix-32 Booth Recoder and Partial-Product Generator

This block turns a signed multiplier operand into a short list of radix-32 signed digits, each between -16 and +16, and forms for every digit the matching multiple of a signed multiplicand. The multiples are already weighted by their digit position and widened to the full product width. A downstream compressor tree and carry-propagate adder can add the rows directly to obtain the signed product. Each digit replaces five multiplier bits, so a 16-bit operand needs only four rows instead of the sixteen rows of a plain array.

The multiplier is read in six-bit windows. Each window shares its lowest bit with the highest bit of the window below it, and the window at the bottom starts with a forced zero. Bits above the operand's top bit are copies of its sign. Each window gives one digit. The set of multiples is built once from shifted copies of the multiplicand. Every row then picks its magnitude from that set and negates it in two's complement when the digit is negative.

Operands enter on every clock where the enable is high. Digits and rows appear in output registers one clock later and hold while the enable is low.

Top module: `r32_booth_ppgen`

## Requirements
- R1: While `rst_n` is low, `digits_o` and `rows_o` are all zero.
- R2: There are G = ceil(WIDTH/5) digits; digit j is the 6-bit two's-complement field `digits_o[6j+5:6j]` and always lies in -16..+16.
- R3: Digit j is built from window bits w0..w5 = multiplier bits 5j-1..5j+4. Bit -1 is zero and bits at or above WIDTH repeat the sign. Each adjacent pair (w[i+1], w[i]) for i = 0..4 contributes 2^i times +1 for 01, -1 for 10, and 0 for 00 or 11.
- R4: The sum over j of digit j times 32^j equals the signed multiplier value.
- R5: Row j is the field `rows_o[2W*j + 2W-1 : 2W*j]`. It equals digit j times the signed multiplicand, shifted left by 5j bits and kept to 2*WIDTH bits. A zero digit gives an all-zero row.
- R6: The sum of all rows, modulo 2^(2*WIDTH), equals the signed product of the two operands.
- R7: Outputs reflect the operands sampled at the previous rising clock edge where `en` was high; with `en` low they hold and input changes have no effect.
- R8: The extreme digits are produced exactly. Window 100000 gives -16 and window 011111 gives +16. The most negative operands (0x8000 for 16 bits) give correct rows and products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture enable for the output registers |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier to be recoded |
| digits_o | output | 6*G | Packed radix-32 digits, digit 0 lowest |
| rows_o | output | 2*WIDTH*G | Packed aligned partial-product rows, row 0 lowest |

## Verification
Every digit and every row is due exactly one rising edge after the edge that samples the operands with `en` high. There are no further pipeline stages. The bench changes inputs on a falling edge and compares outputs on the next falling edge, once that single rising edge has passed. The hold check lowers `en`, changes both operands, and confirms one falling edge later that the earlier results are still present. Reset clearing is checked right after `rst_n` falls, without waiting for a clock.

// File: rtl/r32_booth_pkg.sv
package r32_booth_pkg;
  localparam int DIGIT_W   = 6;
  localparam int GRP_STEP  = 5;
  localparam int MAX_MAG   = 16;
  localparam int MAG_W     = 5;

  typedef struct packed {
    logic             neg;
    logic [MAG_W-1:0] mag;
  } booth_sel_t;
endpackage

// File: rtl/r32_digit_enc.sv
module r32_digit_enc
  import r32_booth_pkg::*;
(
  input  logic [GRP_STEP:0]          win_i,
  output logic signed [DIGIT_W-1:0]  digit_o,
  output booth_sel_t                 sel_o
);
  logic signed [DIGIT_W:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < GRP_STEP; i++) begin
      unique case ({win_i[i+1], win_i[i]})
        2'b01:   acc = acc + (7'sd1 <<< i);
        2'b10:   acc = acc - (7'sd1 <<< i);
        default: acc = acc;
      endcase
    end
  end

  always_comb begin
    digit_o   = acc[DIGIT_W-1:0];
    sel_o.neg = acc[DIGIT_W];
    sel_o.mag = acc[DIGIT_W] ? MAG_W'(-acc) : MAG_W'(acc);
  end
endmodule

// File: rtl/r32_multiple_bank.sv
module r32_multiple_bank
  import r32_booth_pkg::*;
#(
  parameter int AW = 16,
  parameter int MW = AW + 5
) (
  input  logic [AW-1:0]        mcand_i,
  output logic signed [MW-1:0] mult_o [0:MAX_MAG]
);
  logic signed [MW-1:0] a_ext;
  assign a_ext = MW'($signed(mcand_i));

  for (genvar k = 0; k <= MAX_MAG; k++) begin : g_mult
    logic signed [MW-1:0] sum_k;
    always_comb begin
      sum_k = '0;
      for (int b = 0; b < MAG_W; b++) begin
        if (((k >> b) & 1) == 1) sum_k = sum_k + (a_ext <<< b);
      end
    end
    assign mult_o[k] = sum_k;
  end
endmodule

// File: rtl/r32_pp_row.sv
module r32_pp_row
  import r32_booth_pkg::*;
#(
  parameter int MW    = 21,
  parameter int PW    = 32,
  parameter int SHIFT = 0
) (
  input  booth_sel_t           sel_i,
  input  logic signed [MW-1:0] mult_i [0:MAX_MAG],
  output logic [PW-1:0]        row_o
);
  logic signed [MW-1:0] pick;
  logic signed [MW-1:0] signed_m;
  logic signed [PW-1:0] wide;

  always_comb begin
    pick = '0;
    for (int k = 0; k <= MAX_MAG; k++) begin
      if (sel_i.mag == MAG_W'(k)) pick = mult_i[k];
    end
    signed_m = sel_i.neg ? -pick : pick;
    wide     = PW'(signed_m);
    row_o    = wide << SHIFT;
  end
endmodule

// File: rtl/r32_booth_ppgen.sv
module r32_booth_ppgen
  import r32_booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      en,
  input  logic [WIDTH-1:0]                          mcand_i,
  input  logic [WIDTH-1:0]                          mplier_i,
  output logic [DIGIT_W*((WIDTH+4)/5)-1:0]          digits_o,
  output logic [2*WIDTH*((WIDTH+4)/5)-1:0]          rows_o
);
  localparam int NGRP = (WIDTH + GRP_STEP - 1) / GRP_STEP;
  localparam int PW   = 2 * WIDTH;
  localparam int MW   = WIDTH + MAG_W;
  localparam int XW   = NGRP * GRP_STEP;

  logic [XW:0]                 win_src;
  logic signed [MW-1:0]        mult   [0:MAX_MAG];
  logic [DIGIT_W*NGRP-1:0]     digits_nx;
  logic [PW*NGRP-1:0]          rows_nx;

  assign win_src = {XW'($signed(mplier_i)), 1'b0};

  r32_multiple_bank #(.AW(WIDTH), .MW(MW)) u_bank (
    .mcand_i (mcand_i),
    .mult_o  (mult)
  );

  for (genvar j = 0; j < NGRP; j++) begin : g_grp
    logic signed [DIGIT_W-1:0] dig;
    booth_sel_t                sel;
    logic [PW-1:0]             row;

    r32_digit_enc u_enc (
      .win_i   (win_src[GRP_STEP*j +: GRP_STEP+1]),
      .digit_o (dig),
      .sel_o   (sel)
    );

    r32_pp_row #(.MW(MW), .PW(PW), .SHIFT(GRP_STEP*j)) u_row (
      .sel_i  (sel),
      .mult_i (mult),
      .row_o  (row)
    );

    assign digits_nx[DIGIT_W*j +: DIGIT_W] = dig;
    assign rows_nx[PW*j +: PW]             = row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digits_o <= '0;
      rows_o   <= '0;
    end else if (en) begin
      digits_o <= digits_nx;
      rows_o   <= rows_nx;
    end
  end
endmodule

// File: rtl/r32_booth_ppgen_chk.sv
module r32_booth_ppgen_chk
  import r32_booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 en,
  input logic [WIDTH-1:0]                     mcand_i,
  input logic [WIDTH-1:0]                     mplier_i,
  input logic [DIGIT_W*((WIDTH+4)/5)-1:0]     digits_o,
  input logic [2*WIDTH*((WIDTH+4)/5)-1:0]     rows_o
);
  localparam int NGRP = (WIDTH + GRP_STEP - 1) / GRP_STEP;
  localparam int PW   = 2 * WIDTH;

  logic signed [PW-1:0] dsum, rsum, prod_now, mpl_now;

  always_comb begin
    dsum = '0;
    rsum = '0;
    for (int j = 0; j < NGRP; j++) begin
      dsum = dsum + (PW'($signed(digits_o[DIGIT_W*j +: DIGIT_W])) <<< (GRP_STEP*j));
      rsum = rsum + rows_o[PW*j +: PW];
    end
    prod_now = PW'($signed(mcand_i)) * PW'($signed(mplier_i));
    mpl_now  = PW'($signed(mplier_i));
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (digits_o == '0) && (rows_o == '0));

  p_digit_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (dsum == $past(mpl_now)));

  p_row_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (rsum == $past(prod_now)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(digits_o) && $stable(rows_o));

  for (genvar j = 0; j < NGRP; j++) begin : g_chk
    logic signed [DIGIT_W-1:0] d;
    assign d = digits_o[DIGIT_W*j +: DIGIT_W];

    p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (d >= -6'sd16) && (d <= 6'sd16));

    p_zero_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (d == 6'sd0) |-> (rows_o[PW*j +: PW] == '0));
  end
endmodule

bind r32_booth_ppgen r32_booth_ppgen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .mcand_i  (mcand_i),
  .mplier_i (mplier_i),
  .digits_o (digits_o),
  .rows_o   (rows_o)
);

// File: tb/r32_booth_ppgen_test.sv
module r32_booth_ppgen_test;
  localparam int W    = 16;
  localparam int NG   = (W + 4) / 5;
  localparam int PW   = 2 * W;
  localparam int NVEC = 16;

  // {multiplicand, multiplier}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0001, 16'h0001}, {16'hFFFF, 16'hFFFF}, {16'h8000, 16'h8000},
    {16'h7FFF, 16'h7FFF}, {16'h8000, 16'h7FFF}, {16'h7FFF, 16'h8000},
    {16'h0000, 16'h1234}, {16'h1234, 16'h0000}, {16'h1234, 16'h5678},
    {16'hABCD, 16'h0F0F}, {16'h0003, 16'h01F0}, {16'h0005, 16'h0010},
    {16'h0100, 16'h5555}, {16'hAAAA, 16'hAAAA}, {16'h0007, 16'h000F},
    {16'hFFF1, 16'h7C1F}
  };

  logic clk = 1'b0;
  logic rst_n, en;
  logic [W-1:0] mcand, mplier;
  logic [6*NG-1:0]  digits;
  logic [PW*NG-1:0] rows;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  r32_booth_ppgen #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .mcand_i(mcand), .mplier_i(mplier),
    .digits_o(digits), .rows_o(rows)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_digit(input logic [W-1:0] b, input int j);
    logic [31:0] bx;
    int lo, d;
    bx = 32'($signed(b));
    lo = (j == 0) ? 0 : int'(bx[5*j-1]);
    d  = lo + int'(bx[5*j]) + 2*int'(bx[5*j+1]) + 4*int'(bx[5*j+2])
         + 8*int'(bx[5*j+3]) - 16*int'(bx[5*j+4]);
    return d;
  endfunction

  function automatic int out_digit(input int j);
    return int'($signed(digits[6*j +: 6]));
  endfunction

  task automatic check_all(input logic [W-1:0] a, input logic [W-1:0] b);
    int dsum, rsum, exp_row, d, av;
    dsum = 0; rsum = 0;
    av = int'($signed(a));
    for (int j = 0; j < NG; j++) begin
      d = out_digit(j);
      chk(d >= -16 && d <= 16, "R2 digit range", d, 16);
      chk(d == ref_digit(b, j), "R3 digit value", d, ref_digit(b, j));
      exp_row = (ref_digit(b, j) * av) << (5*j);
      chk(rows[PW*j +: PW] == exp_row, "R5 row value",
          int'($signed(rows[PW*j +: PW])), exp_row);
      dsum = dsum + (d << (5*j));
      rsum = rsum + int'(rows[PW*j +: PW]);
    end
    chk(dsum == int'($signed(b)), "R4 digit weighted sum", dsum, int'($signed(b)));
    chk(rsum == av * int'($signed(b)), "R6 row sum", rsum, av * int'($signed(b)));
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    mcand = a; mplier = b; en = 1'b1;
    @(negedge clk);
    check_all(a, b);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; mcand = '0; mplier = '0;
    repeat (3) @(negedge clk);
    chk(digits == '0, "R1 reset digits", longint'(digits), 0);
    chk(rows == '0, "R1 reset rows", 0, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) apply(VEC[v][31:16], VEC[v][15:0]);

    // R8: window 100000 in group 0 and 011111 in group 1
    apply(16'h0003, 16'h01F0);
    chk(out_digit(0) == -16, "R8 digit -16", out_digit(0), -16);
    chk(out_digit(1) == 16, "R8 digit +16", out_digit(1), 16);
    apply(16'h8000, 16'h8000);
    chk(int'($signed(rows[PW*(NG-1) +: PW])) + int'($signed(rows[PW*(NG-2) +: PW]))
        + int'($signed(rows[PW +: PW])) + int'($signed(rows[0 +: PW])) == 32'h4000_0000,
        "R8 most negative product", 0, 32'h4000_0000);

    for (int r = 0; r < 300; r++) apply(W'($urandom), W'($urandom));

    // R7: hold with en low
    apply(16'h1357, 16'h2468);
    @(negedge clk);
    en = 1'b0; mcand = 16'h8000; mplier = 16'h7FFF;
    @(negedge clk);
    check_all(16'h1357, 16'h2468);
    @(negedge clk);
    check_all(16'h1357, 16'h2468);
    // R7: one-cycle latency after enable returns
    en = 1'b1;
    @(negedge clk);
    check_all(16'h8000, 16'h7FFF);

    // R1: asynchronous clear mid-run
    rst_n = 1'b0;
    #1;
    chk(digits == '0, "R1 async clear digits", longint'(digits), 0);
    chk(rows == '0, "R1 async clear rows", 0, 0);
    @(negedge clk);
    chk(digits == '0 && rows == '0, "R1 clear held", 0, 0);
    rst_n = 1'b1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog expired: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule